// File: doc/BRIEF.md
# Paged EEPROM Array Controller

This block is the storage side of a small serial EEPROM. It holds a 4096-byte array, a 12-bit word address counter and a 32-byte page buffer with a per-byte valid mask. A bus-side front end, which is not part of this block, loads an address, pushes received write bytes, pops read bytes and signals the stop that ends a write. Write bytes gather in the page buffer. While they do, the address advances only inside the current 32-byte page. Reads advance across the whole array and wrap from the top back to zero.

A commit request with at least one buffered byte starts a timed write cycle that lasts a parameter number of clocks. The `busy` output stays high for that whole time and every request is ignored. On the clock where `busy` falls, the buffered bytes are copied into the array. If the write-protect input was high when the commit was accepted, bytes aimed at the top quarter of the array are dropped. Between operations the counter holds the last accessed address plus one, so a read with no address load first continues from there.

Top module: `ee_page_store`

## Requirements
- R1: After synchronous reset `busy` is low, `rd_data` is 0x00, the address counter is 0 and every array byte reads 0xFF.
- R2: `addr_load` sets the counter to the low 12 bits of `addr_in`. The upper 4 bits of `addr_in` are ignored.
- R3: `wr_push` stores `wr_data` in page-buffer slot `addr[4:0]` and marks that slot valid. Only `addr[4:0]` then increments, wrapping 31 to 0, and `addr[11:5]` stays fixed. A later push to the same slot overwrites the earlier byte.
- R4: `rd_pop` puts the array byte at the counter on `rd_data` after the next rising edge, and `rd_data` holds until the next accepted pop. The full 12-bit counter then increments, wrapping 4095 to 0.
- R5: Between operations the counter keeps the last accessed address plus one, and a pop with no load first reads from that address.
- R6: A commit with at least one valid buffered byte raises `busy` on the following edge, and `busy` stays high for exactly WR_CYCLES clock cycles.
- R7: On the edge where `busy` falls, every valid buffered byte is written to address {page, slot}. Array bytes whose slot was not valid keep their value, and the buffer is left empty.
- R8: If `wp` was high when the commit was accepted, buffered bytes whose address has bits [11:10] equal to 2'b11 are dropped. All other valid bytes are still written.
- R9: A commit while the page buffer is empty leaves `busy` low and changes no array byte.
- R10: While `busy` is high, load, push, pop and commit requests are ignored. `rd_data` and the counter do not change, and the ignored bytes never reach the array.
- R11: An accepted `addr_load` discards every uncommitted byte in the page buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_load | input | 1 | Load the address counter from `addr_in` |
| addr_in | input | 16 | Word address; only the low 12 bits are used |
| wr_push | input | 1 | Push `wr_data` into the page buffer |
| wr_data | input | 8 | Write byte |
| rd_pop | input | 1 | Read the byte at the counter and advance |
| rd_data | output | 8 | Byte from the last accepted pop |
| commit_req | input | 1 | Stop after write data; start the write cycle |
| wp | input | 1 | Write-protect for the top quarter of the array |
| busy | output | 1 | Timed write cycle in progress |

## Verification
A wrong counter shows on `rd_data` one edge after the next pop. This covers a write that leaked a carry into the page bits, a read that wraps at the page instead of the array, and a load that kept upper input bits. A wrong page buffer or protection decision shows only when the affected address is read back after the write cycle, so the bench reads back whole pages right after each commit. A wrong timer count shows on `busy` on the edge it should change, because `busy` is compared against the model on every clock.

// File: rtl/ee_pkg.sv
package ee_pkg;

    // One request decoded at the block edge, already gated by busy.
    typedef struct packed {
        logic load;
        logic push;
        logic pop;
        logic commit;
    } ee_req_t;

    typedef enum logic {
        TMR_IDLE = 1'b0,
        TMR_RUN  = 1'b1
    } tmr_state_e;

    localparam logic [7:0] ERASED_BYTE = 8'hFF;

    // The locked region is the quarter whose two address MSBs are set.
    function automatic logic in_locked_quarter(input logic [1:0] msb);
        return msb == 2'b11;
    endfunction

endpackage

// File: rtl/ee_addr_ctr.sv
module ee_addr_ctr #(
    parameter int ADDR_W = 12,
    parameter int PAGE_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              step_page,
    input  logic              step_full,
    output logic [ADDR_W-1:0] addr
);
    localparam int ROW_W = ADDR_W - PAGE_W;

    logic [ADDR_W-1:0] addr_q;
    logic [PAGE_W-1:0] col_next;

    assign col_next = addr_q[PAGE_W-1:0] + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
        end else if (load) begin
            addr_q <= load_val;
        end else if (step_page) begin
            addr_q <= {addr_q[ADDR_W-1 -: ROW_W], col_next};
        end else if (step_full) begin
            addr_q <= addr_q + 1'b1;
        end
    end

    assign addr = addr_q;

    // R3: a write step never moves the page row
    a_r3_page_row_kept: assert property (@(posedge clk) disable iff (rst)
        (step_page && !load) |=> addr_q[ADDR_W-1 -: ROW_W] == $past(addr_q[ADDR_W-1 -: ROW_W]));

    // R4: a read step from the top address wraps to zero
    a_r4_full_wrap: assert property (@(posedge clk) disable iff (rst)
        (step_full && !load && !step_page && addr_q == '1) |=> addr_q == '0);

endmodule

// File: rtl/ee_page_buf.sv
module ee_page_buf #(
    parameter int ROW_W  = 7,
    parameter int PAGE_W = 5,
    parameter int DATA_W = 8
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           clear,
    input  logic                           push,
    input  logic [ROW_W-1:0]               row,
    input  logic [PAGE_W-1:0]              slot,
    input  logic [DATA_W-1:0]              din,
    output logic [ROW_W-1:0]               buf_row,
    output logic [(1<<PAGE_W)-1:0]         vld,
    output logic [(1<<PAGE_W)-1:0][DATA_W-1:0] bytes,
    output logic                           any_valid
);
    localparam int SLOTS = 1 << PAGE_W;

    logic [ROW_W-1:0] row_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            row_q <= '0;
        end else if (push) begin
            row_q <= row;
        end
    end

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst || clear) begin
                vld[s] <= 1'b0;
            end else if (push && slot == PAGE_W'(s)) begin
                vld[s] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                bytes[s] <= '0;
            end else if (push && slot == PAGE_W'(s)) begin
                bytes[s] <= din;
            end
        end
    end

    assign buf_row   = row_q;
    assign any_valid = |vld;

    // R11: a clear leaves no valid slot behind
    a_r11_clear_empties: assert property (@(posedge clk) disable iff (rst)
        (clear && !push) |=> !any_valid);

endmodule

// File: rtl/ee_wr_timer.sv
module ee_wr_timer #(
    parameter int WR_CYCLES = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic done
);
    import ee_pkg::*;

    localparam int CNT_W = $clog2(WR_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WR_CYCLES - 1);

    tmr_state_e       st_q;
    logic [CNT_W-1:0] cnt_q;

    assign busy = (st_q == TMR_RUN);
    assign done = busy && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= TMR_IDLE;
            cnt_q <= '0;
        end else begin
            case (st_q)
                TMR_IDLE: begin
                    if (start) begin
                        st_q  <= TMR_RUN;
                        cnt_q <= '0;
                    end
                end
                TMR_RUN: begin
                    if (cnt_q == LAST) begin
                        st_q <= TMR_IDLE;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: st_q <= TMR_IDLE;
            endcase
        end
    end

    // R6: an idle timer given a start is busy on the next edge
    a_r6_start_busy: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    // R6: the final count ends the cycle
    a_r6_end_of_cycle: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

endmodule

// File: rtl/ee_array.sv
module ee_array #(
    parameter int ADDR_W = 12,
    parameter int PAGE_W = 5,
    parameter int DATA_W = 8
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               rd_en,
    input  logic [ADDR_W-1:0]                  rd_addr,
    output logic [DATA_W-1:0]                  rd_data,
    input  logic                               wr_commit,
    input  logic                               wr_lock,
    input  logic [ADDR_W-PAGE_W-1:0]           wr_row,
    input  logic [(1<<PAGE_W)-1:0]             wr_vld,
    input  logic [(1<<PAGE_W)-1:0][DATA_W-1:0] wr_bytes
);
    import ee_pkg::*;

    localparam int DEPTH = 1 << ADDR_W;
    localparam int SLOTS = 1 << PAGE_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [SLOTS-1:0]  slot_we;

    // Per-byte write enable: valid slot, not inside a locked quarter.
    for (genvar s = 0; s < SLOTS; s++) begin : g_we
        logic [ADDR_W-1:0] waddr;
        assign waddr      = {wr_row, PAGE_W'(s)};
        assign slot_we[s] = wr_commit && wr_vld[s] &&
                            !(wr_lock && in_locked_quarter(waddr[ADDR_W-1 -: 2]));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= DATA_W'(ERASED_BYTE);
            end
        end else begin
            for (int s = 0; s < SLOTS; s++) begin
                if (slot_we[s]) begin
                    mem[{wr_row, PAGE_W'(s)}] <= wr_bytes[s];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= mem[rd_addr];
        end
    end

    // R8: nothing in a locked quarter is written while the lock is held
    a_r8_lock_blocks: assert property (@(posedge clk) disable iff (rst)
        (wr_commit && wr_lock && in_locked_quarter(wr_row[ADDR_W-PAGE_W-1 -: 2]))
            |-> slot_we == '0);

    // R10: a read and a commit never share a cycle
    a_r10_no_read_in_commit: assert property (@(posedge clk) disable iff (rst)
        wr_commit |-> !rd_en);

endmodule

// File: rtl/ee_page_store.sv
module ee_page_store #(
    parameter int ADDR_W    = 12,
    parameter int IN_ADDR_W = 16,
    parameter int PAGE_W    = 5,
    parameter int DATA_W    = 8,
    parameter int WR_CYCLES = 20
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 addr_load,
    input  logic [IN_ADDR_W-1:0] addr_in,
    input  logic                 wr_push,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic                 rd_pop,
    output logic [DATA_W-1:0]    rd_data,
    input  logic                 commit_req,
    input  logic                 wp,
    output logic                 busy
);
    import ee_pkg::*;

    localparam int ROW_W = ADDR_W - PAGE_W;
    localparam int SLOTS = 1 << PAGE_W;

    ee_req_t                        req;
    logic [ADDR_W-1:0]              addr;
    logic                           done;
    logic                           start;
    logic                           lock_q;
    logic [ROW_W-1:0]               buf_row;
    logic [SLOTS-1:0]               buf_vld;
    logic [SLOTS-1:0][DATA_W-1:0]   buf_bytes;
    logic                           buf_any;

    // Requests are accepted only outside the write cycle; load wins over push, push over pop.
    always_comb begin
        req        = '0;
        req.load   = !busy && addr_load;
        req.push   = !busy && !addr_load && wr_push;
        req.pop    = !busy && !addr_load && !wr_push && rd_pop;
        req.commit = !busy && commit_req;
    end

    assign start = req.commit && buf_any && !req.load;

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q <= 1'b0;
        end else if (start) begin
            lock_q <= wp;
        end
    end

    ee_addr_ctr #(
        .ADDR_W (ADDR_W),
        .PAGE_W (PAGE_W)
    ) i_ctr (
        .clk       (clk),
        .rst       (rst),
        .load      (req.load),
        .load_val  (addr_in[ADDR_W-1:0]),
        .step_page (req.push),
        .step_full (req.pop),
        .addr      (addr)
    );

    ee_page_buf #(
        .ROW_W  (ROW_W),
        .PAGE_W (PAGE_W),
        .DATA_W (DATA_W)
    ) i_buf (
        .clk       (clk),
        .rst       (rst),
        .clear     (req.load || done),
        .push      (req.push),
        .row       (addr[ADDR_W-1 -: ROW_W]),
        .slot      (addr[PAGE_W-1:0]),
        .din       (wr_data),
        .buf_row   (buf_row),
        .vld       (buf_vld),
        .bytes     (buf_bytes),
        .any_valid (buf_any)
    );

    ee_wr_timer #(
        .WR_CYCLES (WR_CYCLES)
    ) i_tmr (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .busy  (busy),
        .done  (done)
    );

    ee_array #(
        .ADDR_W (ADDR_W),
        .PAGE_W (PAGE_W),
        .DATA_W (DATA_W)
    ) i_arr (
        .clk       (clk),
        .rst       (rst),
        .rd_en     (req.pop),
        .rd_addr   (addr),
        .rd_data   (rd_data),
        .wr_commit (done),
        .wr_lock   (lock_q),
        .wr_row    (buf_row),
        .wr_vld    (buf_vld),
        .wr_bytes  (buf_bytes)
    );

    // R9: a commit on an empty buffer never starts a cycle
    a_r9_empty_commit: assert property (@(posedge clk) disable iff (rst)
        (commit_req && !busy && !buf_any) |=> !busy);

    // R10: the counter is frozen during the write cycle
    a_r10_addr_frozen: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(addr));

    // R10: read data is frozen during the write cycle
    a_r10_rd_frozen: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(rd_data));

endmodule

// File: tb/test_ee_page_store.sv
`timescale 1ns/1ps
module test_ee_page_store;

    localparam int WR = 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        addr_load = 1'b0;
    logic [15:0] addr_in = '0;
    logic        wr_push = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        rd_pop = 1'b0;
    logic [7:0]  rd_data;
    logic        commit_req = 1'b0;
    logic        wp = 1'b0;
    logic        busy;

    always #2.5 clk = ~clk;

    ee_page_store #(.WR_CYCLES(WR)) i_ee_page_store (
        .clk(clk), .rst(rst), .addr_load(addr_load), .addr_in(addr_in),
        .wr_push(wr_push), .wr_data(wr_data), .rd_pop(rd_pop), .rd_data(rd_data),
        .commit_req(commit_req), .wp(wp), .busy(busy)
    );

    // ---------------- behavioural reference ----------------
    logic [7:0] m_mem [4096];
    logic [7:0] m_buf [32];
    bit         m_vld [32];
    int         m_row, m_ctr, m_cnt;
    bit         m_busy, m_lock;
    logic [7:0] m_rd;

    always @(posedge clk) begin
        if (rst) begin
            foreach (m_mem[i]) m_mem[i] = 8'hFF;
            foreach (m_vld[i]) m_vld[i] = 0;
            m_row = 0; m_ctr = 0; m_cnt = 0; m_busy = 0; m_lock = 0; m_rd = 8'h00;
        end else if (m_busy) begin
            m_cnt++;
            if (m_cnt == WR) begin
                m_busy = 0;
                for (int j = 0; j < 32; j++) begin
                    if (m_vld[j]) begin
                        int a;
                        a = m_row * 32 + j;
                        if (!(m_lock && a >= 3072)) m_mem[a] = m_buf[j];
                        m_vld[j] = 0;
                    end
                end
            end
        end else begin
            bit any;
            any = 0;
            foreach (m_vld[i]) if (m_vld[i]) any = 1;
            if (commit_req && any && !addr_load) begin
                m_busy = 1; m_cnt = 0; m_lock = wp;
            end
            if (addr_load) begin
                m_ctr = addr_in % 4096;
                foreach (m_vld[i]) m_vld[i] = 0;
            end else if (wr_push) begin
                m_buf[m_ctr % 32] = wr_data;
                m_vld[m_ctr % 32] = 1;
                m_row = m_ctr / 32;
                m_ctr = (m_ctr / 32) * 32 + ((m_ctr + 1) % 32);
            end else if (rd_pop) begin
                m_rd = m_mem[m_ctr];
                m_ctr = (m_ctr + 1) % 4096;
            end
        end
    end

    // ---------------- comparison every clock ----------------
    int    total = 0, bad = 0, cycles = 0;
    string tag = "R1";
    bit    run_chk = 0;

    task automatic check(input bit ok, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        if (run_chk) begin
            check(busy === m_busy, "busy", int'(busy), int'(m_busy));
            check(rd_data === m_rd, "rd_data", int'(rd_data), int'(m_rd));
        end
        if (cycles > 100000) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    task automatic tick();
        @(negedge clk);
        addr_load = 0; wr_push = 0; rd_pop = 0; commit_req = 0;
    endtask
    task automatic do_load(input logic [15:0] a);
        addr_load = 1; addr_in = a; tick();
    endtask
    task automatic do_push(input logic [7:0] d);
        wr_push = 1; wr_data = d; tick();
    endtask
    task automatic do_pop(input int n);
        for (int i = 0; i < n; i++) begin rd_pop = 1; tick(); end
    endtask
    task automatic do_commit(input bit w);
        commit_req = 1; wp = w; tick();
    endtask
    task automatic wait_idle();
        for (int i = 0; i < WR + 4; i++) tick();
    endtask
    task automatic read_page(input logic [15:0] a);
        do_load(a); do_pop(32);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        run_chk = 1;
        // R1: reset state, erased array
        tag = "R1";
        tick();
        do_pop(4);
        // R2: upper address bits ignored; R3: in-page wrap of the write address
        tag = "R2";
        do_load(16'hF07C);
        tag = "R3";
        for (int i = 0; i < 6; i++) do_push(8'h10 + 8'(i));
        tag = "R6";
        do_commit(0);
        wait_idle();
        tag = "R3";
        read_page(16'h0060);
        // R3: more than 32 bytes overwrite earlier bytes in the page
        do_load(16'h0105);
        for (int i = 0; i < 40; i++) do_push(8'h80 + 8'(i));
        tag = "R7";
        do_commit(0);
        wait_idle();
        read_page(16'h0100);
        // R7: partial page keeps unwritten bytes
        do_load(16'h0108);
        do_push(8'h5A); do_push(8'hA5);
        do_commit(0);
        wait_idle();
        read_page(16'h0100);
        // R5: counter continues from last access + 1
        tag = "R5";
        do_load(16'h0103);
        do_pop(2);
        tick(); tick();
        do_pop(3);
        // R8: locked quarter drops bytes, unlocked region still written with wp high
        tag = "R8";
        do_load(16'h0C10);
        for (int i = 0; i < 4; i++) do_push(8'h30 + 8'(i));
        do_commit(1);
        wait_idle();
        read_page(16'h0C00);
        do_load(16'h0400);
        for (int i = 0; i < 3; i++) do_push(8'h44 + 8'(i));
        do_commit(1);
        wait_idle();
        read_page(16'h0400);
        do_load(16'h0FE0);
        for (int i = 0; i < 3; i++) do_push(8'hC0 + 8'(i));
        do_commit(0);
        wait_idle();
        read_page(16'h0FE0);
        // R9: commit with empty buffer
        tag = "R9";
        do_commit(0);
        tick(); tick();
        do_load(16'h0200);
        do_commit(0);
        tick(); tick();
        // R10: requests during the write cycle are ignored
        tag = "R10";
        do_load(16'h0300);
        do_push(8'h77);
        do_commit(0);
        do_load(16'h0320);
        do_push(8'h99);
        do_pop(2);
        do_commit(0);
        wait_idle();
        do_pop(2);
        read_page(16'h0300);
        read_page(16'h0320);
        // R11: a load discards uncommitted bytes
        tag = "R11";
        do_load(16'h0500);
        do_push(8'hEE); do_push(8'hEF);
        do_load(16'h0500);
        do_commit(0);
        tick(); tick();
        read_page(16'h0500);
        // R4: read wrap across the whole array
        tag = "R4";
        do_load(16'h0FFE);
        do_pop(5);
        tick(); tick();
        run_chk = 0;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule